// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches one external event pin and, when the chosen kind of event appears on it, copies the present value of a free-running timer into a capture register. It also raises a sticky flag for an interrupt controller. Four event kinds can be chosen: a single falling edge, a single rising edge, every fourth rising edge, or every sixteenth rising edge. Two timer buses arrive at the block, and a select input decides which one is copied.

Software programs a 4-bit mode register through a write strobe and can read the mode back. It reads the captured value as a high byte and a low byte, and it clears the flag with a separate strobe. The pin is brought into the clock domain by a synchronizer chain before its edges are detected.

The rising-edge divider keeps its count while the module moves from one divider setting to the other. As a result, the first capture after such a move can come after fewer edges than the new setting implies. Writing the off code first clears the count.

Top module: `evtcap_top`

## Requirements
- R1: After reset the mode readback, the capture bytes and the flag are all zero. A write strobe loads `mode_wdata` into the mode register, and `mode_rd` shows it from the next cycle on.
- R2: In mode 4'b0100, every falling edge of `evt_pin` causes a capture. A pin level first sampled at clock edge k is captured at edge k+2, with the timer value present at that edge. A rising edge in this mode captures nothing.
- R3: In mode 4'b0101, every rising edge of `evt_pin` causes a capture, with the same two-edge latency as R2.
- R4: In mode 4'b0110, entered from the off state, the first three rising edges capture nothing and the fourth causes a capture. The divider then restarts.
- R5: In mode 4'b0111, entered from the off state, the first fifteen rising edges capture nothing and the sixteenth causes a capture.
- R6: With `tmr_sel` low the capture copies `tmr_a`. With `tmr_sel` high it copies `tmr_b`. `cap_hi` holds bits 15:8 and `cap_lo` holds bits 7:0.
- R7: A capture sets `cap_flag`. The flag stays set until a `flag_clr` strobe arrives in a cycle without a capture. A capture and a clear in the same cycle leave the flag set.
- R8: A later capture overwrites the captured value whether or not it was read, and no overrun is signalled.
- R9: Mode 4'b0000 and every code outside 4'b0100..4'b0111 make no capture and clear the rising-edge divider count.
- R10: Moving directly between 4'b0111 and 4'b0110 keeps the divider count. After six rising edges in 4'b0111 and a direct write of 4'b0110, the next rising edge causes a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pin | input | 1 | External event pin, asynchronous to clk |
| tmr_a | input | 16 | First timer source |
| tmr_b | input | 16 | Second timer source |
| tmr_sel | input | 1 | Timer source select, 1 picks tmr_b |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode value to write |
| flag_clr | input | 1 | Capture flag clear strobe |
| mode_rd | output | 4 | Mode register readback |
| cap_hi | output | 8 | Captured value, upper byte |
| cap_lo | output | 8 | Captured value, lower byte |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The bench builds the block with its defaults: a 16-bit timer, two synchronizer stages and dividers of 4 and 16. At these values the whole sixteen-edge divider cycle runs in a few hundred clocks, so the count can be walked edge by edge. The same settings allow a direct move from the divide-by-16 setting to the divide-by-4 setting with a count already above the new limit. A distinct timer pattern on each source shows which bus was copied and in which cycle.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      CM_OFF     = 4'b0000,
      CM_FALL    = 4'b0100,
      CM_RISE    = 4'b0101,
      CM_RISE_D4 = 4'b0110,
      CM_RISE_DN = 4'b0111
   } cap_mode_e;

   function automatic logic mode_active(input logic [MODE_W-1:0] m);
      return (m[MODE_W-1:2] == 2'b01);
   endfunction

   function automatic logic mode_divided(input logic [MODE_W-1:0] m);
      return (m == CM_RISE_D4) || (m == CM_RISE_DN);
   endfunction

endpackage

// File: rtl/evtcap_edge.sv
module evtcap_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("evtcap_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[0] <= 1'b0;
      else        sh_q[0] <= pin;
   end

   generate
      for (genvar i = 1; i <= STAGES; i++) begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
         end
      end
   endgenerate

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

   // R3: one synchronized transition gives at most one edge pulse
   a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   // R2: falling pulses are isolated in the same way
   a_r2_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/evtcap_prescale.sv
module evtcap_prescale #(
   parameter int DIV_A = 4,
   parameter int DIV_B = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic use_div,
   input  logic pick_b,
   input  logic rise,
   output logic hit
);

   localparam int CNT_W = (DIV_B > 2) ? $clog2(DIV_B) : 1;
   localparam logic [CNT_W-1:0] LIM_A = CNT_W'(DIV_A - 1);
   localparam logic [CNT_W-1:0] LIM_B = CNT_W'(DIV_B - 1);

   generate
      if (DIV_A < 2 || DIV_B <= DIV_A) begin : g_bad_div
         $error("evtcap_prescale: need 2 <= DIV_A < DIV_B");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             at_lim;

   assign limit  = pick_b ? LIM_B : LIM_A;
   assign at_lim = (cnt_q >= limit);
   assign hit    = use_div & rise & at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (use_div && rise) begin
         cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
      end
   end

   // R9: an inactive mode leaves the count at zero
   a_r9_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));
   // R10: without a rising edge the count is kept, also across divider changes
   a_r10_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !rise) |=> $stable(cnt_q));

endmodule

// File: rtl/evtcap_hold.sv
module evtcap_hold #(
   parameter int TMR_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [TMR_W-1:0]   din,
   output logic [TMR_W/2-1:0] hi,
   output logic [TMR_W/2-1:0] lo
);

   localparam int HALF = TMR_W / 2;

   generate
      if (TMR_W < 2 || (TMR_W % 2) != 0) begin : g_bad_width
         $error("evtcap_hold: TMR_W must be even and at least 2");
      end
   endgenerate

   logic [TMR_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= '0;
      else if (load) val_q <= din;
   end

   assign hi = val_q[TMR_W-1:HALF];
   assign lo = val_q[HALF-1:0];

   // R8: the held value changes only on a load and takes the new data
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(val_q));
   a_r8_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (val_q == $past(din)));

endmodule

// File: rtl/evtcap_top.sv
module evtcap_top #(
   parameter int TMR_W  = 16,
   parameter int STAGES = 2,
   parameter int DIV_A  = 4,
   parameter int DIV_B  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_pin,
   input  logic [TMR_W-1:0]   tmr_a,
   input  logic [TMR_W-1:0]   tmr_b,
   input  logic               tmr_sel,
   input  logic               mode_we,
   input  logic [3:0]         mode_wdata,
   input  logic               flag_clr,
   output logic [3:0]         mode_rd,
   output logic [TMR_W/2-1:0] cap_hi,
   output logic [TMR_W/2-1:0] cap_lo,
   output logic               cap_flag
);
   import evtcap_pkg::*;

   logic [MODE_W-1:0] mode_q;
   logic              rise, fall, div_hit, cap_evt, flag_q;
   logic [TMR_W-1:0]  tmr_pick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= CM_OFF;
      else if (mode_we) mode_q <= mode_wdata;
   end

   evtcap_edge #(.STAGES(STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (evt_pin),
      .rise (rise),
      .fall (fall)
   );

   evtcap_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!mode_active(mode_q)),
      .use_div(mode_divided(mode_q)),
      .pick_b (mode_q == CM_RISE_DN),
      .rise   (rise),
      .hit    (div_hit)
   );

   assign cap_evt = ((mode_q == CM_FALL) & fall)
                  | ((mode_q == CM_RISE) & rise)
                  | div_hit;

   assign tmr_pick = tmr_sel ? tmr_b : tmr_a;

   evtcap_hold #(.TMR_W(TMR_W)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cap_evt),
      .din  (tmr_pick),
      .hi   (cap_hi),
      .lo   (cap_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (cap_evt)  flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign cap_flag = flag_q;
   assign mode_rd  = mode_q;

   // R7: a capture always leaves the flag set, even against a clear
   a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> cap_flag);
   // R7: the flag only drops on a clear strobe
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag && !flag_clr) |=> cap_flag);
   // R9: inactive codes never capture
   a_r9_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_active(mode_q) |-> !cap_evt);
   // R6: the captured word is the selected timer at the capture edge
   a_r6_source: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> ({cap_hi, cap_lo} == $past(tmr_sel ? tmr_b : tmr_a)));

endmodule

// File: tb/evtcap_top_bench.sv
module evtcap_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_pin = 1'b0;
   logic [15:0] tmr_a, tmr_b;
   logic        tmr_sel = 1'b0;
   logic        mode_we = 1'b0;
   logic [3:0]  mode_wdata = 4'd0;
   logic        flag_clr = 1'b0;
   logic [3:0]  mode_rd;
   logic [7:0]  cap_hi, cap_lo;
   logic        cap_flag;

   int n_vec = 0;
   int n_bad = 0;
   logic [31:0] cyc = 0;

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;
   assign tmr_a = cyc[15:0] * 16'd7 + 16'd3;
   assign tmr_b = {cyc[7:0], cyc[15:8]} ^ 16'hA5C3;

   evtcap_top u_evtcap_top (
      .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin),
      .tmr_a(tmr_a), .tmr_b(tmr_b), .tmr_sel(tmr_sel),
      .mode_we(mode_we), .mode_wdata(mode_wdata), .flag_clr(flag_clr),
      .mode_rd(mode_rd), .cap_hi(cap_hi), .cap_lo(cap_lo), .cap_flag(cap_flag)
   );

   // behavioural reference, updated at each rising clock edge
   int          m_mode, m_cnt, m_flag;
   logic [15:0] m_cap;
   bit          pin_hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_flag = 0; m_cap = 0;
         pin_hist = '{0, 0, 0};
      end else begin
         bit r, f, act, dv, ev;
         int lim;
         r   = pin_hist[1] && !pin_hist[2];
         f   = !pin_hist[1] && pin_hist[2];
         act = (m_mode >= 4 && m_mode <= 7);
         dv  = (m_mode == 6 || m_mode == 7);
         lim = (m_mode == 7) ? 15 : 3;
         ev  = (m_mode == 4 && f) || (m_mode == 5 && r) || (dv && r && m_cnt >= lim);
         if (!act) m_cnt = 0;
         else if (dv && r) m_cnt = (m_cnt >= lim) ? 0 : m_cnt + 1;
         if (ev) m_cap = tmr_sel ? tmr_b : tmr_a;
         if (ev) m_flag = 1; else if (flag_clr) m_flag = 0;
         if (mode_we) m_mode = int'(mode_wdata);
         pin_hist.push_front(evt_pin);
         void'(pin_hist.pop_back());
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 mode", int'(mode_rd), m_mode);
         check("R8 capture", int'({cap_hi, cap_lo}), int'(m_cap));
         check("R7 flag", int'(cap_flag), m_flag);
      end
   end

   task automatic wr_mode(input logic [3:0] v);
      @(negedge clk); mode_we = 1'b1; mode_wdata = v;
      @(negedge clk); mode_we = 1'b0;
   endtask

   task automatic clr_flag();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); evt_pin = 1'b1;
         repeat (3) @(negedge clk);
         evt_pin = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      #(20 * 20000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] exp_v;
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 reset mode", int'(mode_rd), 0);
      check("R1 reset cap", int'({cap_hi, cap_lo}), 0);
      check("R1 reset flag", int'(cap_flag), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 falling-edge capture with exact latency
      wr_mode(4'b0100);
      check("R1 readback", int'(mode_rd), 4);
      evt_pin = 1'b1; repeat (4) @(negedge clk);
      check("R2 rise ignored", int'(cap_flag), 0);
      evt_pin = 1'b0;
      @(negedge clk); @(negedge clk);
      exp_v = tmr_a;
      @(negedge clk);
      check("R2 fall capture", int'({cap_hi, cap_lo}), int'(exp_v));
      check("R7 flag set", int'(cap_flag), 1);
      clr_flag();
      check("R7 flag cleared", int'(cap_flag), 0);

      // R7 capture and clear in the same cycle
      evt_pin = 1'b1; repeat (4) @(negedge clk);
      evt_pin = 1'b0;
      @(negedge clk); @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      check("R7 capture beats clear", int'(cap_flag), 1);
      clr_flag();

      // R3 / R6 rising capture from the second source
      wr_mode(4'b0101);
      tmr_sel = 1'b1;
      evt_pin = 1'b1;
      @(negedge clk); @(negedge clk);
      exp_v = tmr_b;
      @(negedge clk);
      check("R3 R6 rise capture tmr_b", int'({cap_hi, cap_lo}), int'(exp_v));
      check("R6 low byte", int'(cap_lo), int'(exp_v[7:0]));
      evt_pin = 1'b0; repeat (3) @(negedge clk);
      tmr_sel = 1'b0;

      // R8 overwrite without reading
      pulse(1);
      exp_v = {cap_hi, cap_lo};
      pulse(1);
      check("R8 second capture differs", int'({cap_hi, cap_lo} != exp_v), 1);
      clr_flag();

      // R4 divide by four from off
      wr_mode(4'b0000); wr_mode(4'b0110);
      pulse(3);
      check("R4 three edges no capture", int'(cap_flag), 0);
      pulse(1);
      check("R4 fourth edge captures", int'(cap_flag), 1);
      clr_flag();

      // R5 divide by sixteen from off
      wr_mode(4'b0000); wr_mode(4'b0111);
      pulse(15);
      check("R5 fifteen edges no capture", int'(cap_flag), 0);
      pulse(1);
      check("R5 sixteenth edge captures", int'(cap_flag), 1);
      clr_flag();

      // R9 other codes inactive, off clears the count
      wr_mode(4'b1000);
      exp_v = {cap_hi, cap_lo};
      pulse(2);
      check("R9 code 1000 no flag", int'(cap_flag), 0);
      check("R9 code 1000 no capture", int'({cap_hi, cap_lo}), int'(exp_v));
      wr_mode(4'b0110);
      pulse(2);
      wr_mode(4'b0000); wr_mode(4'b0110);
      pulse(3);
      check("R9 off cleared count", int'(cap_flag), 0);
      pulse(1);
      check("R9 fourth after restart", int'(cap_flag), 1);
      clr_flag();

      // R10 direct divider change keeps the count
      wr_mode(4'b0000); wr_mode(4'b0111);
      pulse(6);
      wr_mode(4'b0110);
      check("R10 no flag before", int'(cap_flag), 0);
      pulse(1);
      check("R10 early capture", int'(cap_flag), 1);

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule